// File: doc/BRIEF.md
# PCI Interrupt Line Router with Group Gating

This block turns level-sensitive interrupt requests from PCI functions into 32 level lines for an interrupt controller. Each request names its path (a function on the primary bus, or a function behind one of two secondary bridges), its device/function number, its pin index and its new level. The router works out the line number in two steps. Behind a bridge, the slot bits of the device/function number are first folded into the pin index. The bus offset is then added. That offset is chosen by device/function bit 0 on the primary bus, or by the bridge select for the two bridges, which sit at an even and an odd function number. The router keeps the most recent level of every line.

Eight map registers each govern four consecutive lines. Only bit 31 of a map register can change, and it enables its group. When the bit is clear, the group's outputs are held low while the stored levels stay intact. Bits 30:0 are fixed identification values that always read back the same. Outputs are registered. A request or an enable write seen at a clock edge is visible on the outputs right after that edge.

Top module: `irq_router`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs go low, all stored request levels are cleared and all eight enable bits (bit 31) are cleared.
- R2: Map register i (selected by `reg_addr` = i) reads back as bit 31 = enable and bits 30:0 = 0x7C0 OR (i << 2). After reset every enable bit reads 0.
- R3: A write to map register i changes only its bit 31, taken from `reg_wdata[31]`. Bits 30:0 of the write data have no effect on the read-back value.
- R4: A reset applied after enables were set clears bit 31 of all eight registers and leaves bits 30:0 at 0x7C0 OR (i << 2).
- R5: Line n is governed by map register n/4. While that register's bit 31 is 0, `irq_out[n]` is low whatever its request level.
- R6: While its group is enabled, `irq_out[n]` equals the level of the last accepted request for line n. The level is visible after the same clock edge at which `req_valid` was sampled.
- R7: A primary-bus request (`req_sec` = 0) maps to line 16 + pin when device/function bit 0 is 1, and to line pin otherwise.
- R8: A secondary request (`req_sec` = 1) maps to line 16*`req_bridge` + ((devfn AND 0x18) >> 1) + pin.
- R9: A request whose computed line is 32 or more is dropped and leaves every output and stored level unchanged. The pin field is 3 bits wide and is added in full.
- R10: When an enable bit changes, the four lines of that group re-evaluate against the stored levels at the same edge as the write. Re-enabling a group restores the lines that were requested while it was disabled.
- R11: An accepted request changes only the stored level of its own line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_sec | input | 1 | 1 = request comes from behind a secondary bridge |
| req_bridge | input | 1 | Which secondary bridge (0 or 1) |
| req_devfn | input | 8 | Device/function number of the requester |
| req_pin | input | 3 | Pin index (normally 0 to 3) |
| req_level | input | 1 | New level of the request |
| reg_wr | input | 1 | Map register write strobe |
| reg_addr | input | 3 | Map register index |
| reg_wdata | input | 32 | Write data; only bit 31 is used |
| reg_rdata | output | 32 | Read data of the selected map register (combinational) |
| irq_out | output | 32 | Gated interrupt lines |

## Verification
The assertions assume at most one request per cycle and do not check enable changes against request events in the same cycle. The property for dropped requests therefore only applies in cycles without a register write, and the bench never issues a write and a request together. Inputs change one time unit after a rising edge and are held through the next edge. Outputs are sampled just after the edge at which the change takes effect. The stimulus includes pins 4 to 7 so that lines past 31 can be produced.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int NUM_MAPS      = 8;
    localparam int LINES_PER_MAP = 4;
    localparam int NUM_LINES     = NUM_MAPS * LINES_PER_MAP;
    localparam int IDX_W         = $clog2(NUM_LINES);
    localparam int LINE_W        = IDX_W + 1;
    localparam int MAP_AW        = $clog2(NUM_MAPS);
    localparam int DEVFN_W       = 8;
    localparam int PIN_W         = 3;
    localparam int DATA_W        = 32;
    localparam int EN_BIT        = DATA_W - 1;
    localparam int BUS_OFS       = NUM_LINES / 2;
    localparam logic [DEVFN_W-1:0] SLOT_MASK = 8'h18;
    localparam int ID_BASE       = 32'h1F << 6;

    typedef struct packed {
        logic               valid;
        logic               sec;
        logic               bridge;
        logic [DEVFN_W-1:0] devfn;
        logic [PIN_W-1:0]   pin;
        logic               level;
    } irq_req_t;

    typedef struct packed {
        logic              hit;
        logic [LINE_W-1:0] line;
        logic              level;
    } irq_evt_t;

    function automatic logic [EN_BIT-1:0] map_ident(input int unsigned idx);
        return EN_BIT'(32'(ID_BASE) | (32'(idx) << 2));
    endfunction

    function automatic logic [NUM_LINES-1:0] spread_en(input logic [NUM_MAPS-1:0] en);
        logic [NUM_LINES-1:0] r;
        for (int n = 0; n < NUM_LINES; n++) begin
            r[n] = en[n / LINES_PER_MAP];
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_line_calc.sv
module irq_line_calc
    import irq_route_pkg::*;
(
    input  irq_req_t req,
    output irq_evt_t evt
);

    logic [LINE_W-1:0] fold_ofs;
    logic [LINE_W-1:0] pin_ext;
    logic [LINE_W-1:0] stage1;
    logic [LINE_W-1:0] bus_ofs;
    logic [LINE_W-1:0] line;
    logic              bus_sel;

    always_comb begin
        // stage 1: bridge fold of the slot bits into the pin index
        fold_ofs = LINE_W'((req.devfn & SLOT_MASK) >> 1);
        pin_ext  = LINE_W'(req.pin);
        stage1   = req.sec ? (fold_ofs + pin_ext) : pin_ext;
        // stage 2: bus offset from the function bit seen on the primary bus
        bus_sel  = req.sec ? req.bridge : req.devfn[0];
        bus_ofs  = bus_sel ? LINE_W'(BUS_OFS) : '0;
        line     = bus_ofs + stage1;
        evt.line  = line;
        evt.level = req.level;
        evt.hit   = req.valid && (line < LINE_W'(NUM_LINES));
    end

    // R7: primary requests with a legal pin keep pin in the low bits and devfn[0] as the half select
    always_comb begin
        if (!$isunknown(req) && req.valid && !req.sec && (req.pin < 3'd4)) begin
            a_r7_primary_map: assert (line[IDX_W-1] == req.devfn[0] && line[1:0] == req.pin[1:0]);
        end
    end

endmodule

// File: rtl/irq_map_regs.sv
module irq_map_regs
    import irq_route_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [MAP_AW-1:0]   addr,
    input  logic                wr_en_bit,
    output logic [NUM_MAPS-1:0] en_q,
    output logic [NUM_MAPS-1:0] en_nxt,
    output logic [DATA_W-1:0]   rdata
);

    logic [EN_BIT-1:0] ident [NUM_MAPS];

    generate
        for (genvar i = 0; i < NUM_MAPS; i++) begin : g_ident
            assign ident[i] = map_ident(i);
        end
    endgenerate

    always_comb begin
        en_nxt = en_q;
        if (wr) begin
            en_nxt[addr] = wr_en_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q <= en_nxt;
        end
    end

    assign rdata = {en_q[addr], ident[addr]};

    // R3: without a write strobe the enable bits hold
    a_r3_en_hold: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(en_q));

    // R4: reset leaves every enable bit cleared
    a_r4_reset_clears_en: assert property (@(posedge clk)
        rst |=> (en_q == '0));

endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate
    import irq_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  irq_evt_t             evt,
    input  logic [NUM_MAPS-1:0]  en_nxt,
    output logic [NUM_LINES-1:0] irq_out
);

    logic [NUM_LINES-1:0] lvl_q;
    logic [NUM_LINES-1:0] lvl_nxt;
    logic [NUM_LINES-1:0] line_en;

    always_comb begin
        lvl_nxt = lvl_q;
        if (evt.hit) begin
            lvl_nxt[evt.line[IDX_W-1:0]] = evt.level;
        end
    end

    generate
        for (genvar g = 0; g < NUM_MAPS; g++) begin : g_group
            assign line_en[g*LINES_PER_MAP +: LINES_PER_MAP] = {LINES_PER_MAP{en_nxt[g]}};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= '0;
            irq_out <= '0;
        end else begin
            lvl_q   <= lvl_nxt;
            irq_out <= lvl_nxt & line_en;
        end
    end

    // R1: reset drives every line low
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> (irq_out == '0));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_sec,
    input  logic                 req_bridge,
    input  logic [DEVFN_W-1:0]   req_devfn,
    input  logic [PIN_W-1:0]     req_pin,
    input  logic                 req_level,
    input  logic                 reg_wr,
    input  logic [MAP_AW-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [NUM_LINES-1:0] irq_out
);

    irq_req_t            req;
    irq_evt_t            evt;
    logic [NUM_MAPS-1:0] en_q;
    logic [NUM_MAPS-1:0] en_nxt;

    assign req = '{valid:  req_valid,
                   sec:    req_sec,
                   bridge: req_bridge,
                   devfn:  req_devfn,
                   pin:    req_pin,
                   level:  req_level};

    irq_line_calc u_calc (
        .req (req),
        .evt (evt)
    );

    irq_map_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wr_en_bit (reg_wdata[EN_BIT]),
        .en_q      (en_q),
        .en_nxt    (en_nxt),
        .rdata     (reg_rdata)
    );

    irq_level_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .en_nxt  (en_nxt),
        .irq_out (irq_out)
    );

    // R5: a line whose group is disabled never shows high
    a_r5_disabled_low: assert property (@(posedge clk) disable iff (rst)
        (irq_out & ~spread_en(en_q)) == '0);

    // R9: an out-of-range request with no register write leaves the outputs alone
    a_r9_drop_far_line: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !evt.hit && !reg_wr) |=> (irq_out == $past(irq_out)));

endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;
    import irq_route_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 req_valid, req_sec, req_bridge, req_level;
    logic [DEVFN_W-1:0]   req_devfn;
    logic [PIN_W-1:0]     req_pin;
    logic                 reg_wr;
    logic [MAP_AW-1:0]    reg_addr;
    logic [DATA_W-1:0]    reg_wdata;
    logic [DATA_W-1:0]    reg_rdata;
    logic [NUM_LINES-1:0] irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [NUM_LINES-1:0] m_lvl;
    logic [NUM_MAPS-1:0]  m_en;

    always #5 clk = ~clk;

    irq_router u0 (.*);

    // {sec, bridge, devfn, pin, level, expected line (63 = dropped)}
    localparam int NV = 13;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h00, 3'd0, 1'b1, 6'd0},
        {1'b0, 1'b0, 8'h01, 3'd2, 1'b1, 6'd18},
        {1'b0, 1'b0, 8'h10, 3'd3, 1'b1, 6'd3},
        {1'b1, 1'b0, 8'h08, 3'd1, 1'b1, 6'd5},
        {1'b1, 1'b1, 8'h18, 3'd3, 1'b1, 6'd31},
        {1'b1, 1'b1, 8'h10, 3'd0, 1'b1, 6'd24},
        {1'b1, 1'b0, 8'h07, 3'd2, 1'b1, 6'd2},
        {1'b0, 1'b0, 8'h01, 3'd2, 1'b0, 6'd18},
        {1'b1, 1'b1, 8'h18, 3'd7, 1'b1, 6'd63},
        {1'b0, 1'b0, 8'h05, 3'd4, 1'b1, 6'd20},
        {1'b1, 1'b0, 8'h1F, 3'd0, 1'b1, 6'd12},
        {1'b1, 1'b1, 8'h18, 3'd5, 1'b1, 6'd63},
        {1'b0, 1'b0, 8'h00, 3'd0, 1'b0, 6'd0}
    };
    localparam string TAG [NV] = '{"R7", "R7", "R7", "R8", "R8", "R8", "R8",
                                   "R11", "R9", "R6", "R8", "R9", "R11"};

    function automatic logic [NUM_LINES-1:0] model_out();
        logic [NUM_LINES-1:0] r;
        for (int n = 0; n < NUM_LINES; n++) r[n] = m_lvl[n] & m_en[n / LINES_PER_MAP];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send(input logic s, input logic b, input logic [7:0] d,
                        input logic [2:0] p, input logic l);
        req_valid = 1'b1; req_sec = s; req_bridge = b;
        req_devfn = d; req_pin = p; req_level = l;
        step();
        req_valid = 1'b0;
    endtask

    task automatic wr_map(input int i, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = MAP_AW'(i); reg_wdata = d;
        step();
        reg_wr = 1'b0;
        m_en[i] = d[31];
    endtask

    task automatic rd_chk(input string tag, input int i, input logic en);
        reg_addr = MAP_AW'(i);
        #1;
        chk(tag, reg_rdata, {en, 31'(32'h7C0 | (i << 2))});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        m_lvl = '0;
        m_en  = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        req_valid = 0; req_sec = 0; req_bridge = 0; req_devfn = '0;
        req_pin = '0; req_level = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
        #1;
        do_reset();

        // R1 / R2: reset state
        chk("R1", irq_out, '0);
        for (int i = 0; i < NUM_MAPS; i++) rd_chk("R2", i, 1'b0);

        // R3: enable every group, with junk in the lower bits
        for (int i = 0; i < NUM_MAPS; i++) wr_map(i, 32'h8123_4567);
        rd_chk("R3", 0, 1'b1);
        rd_chk("R3", 5, 1'b1);

        // vector walk: R6 R7 R8 R9 R11
        for (int v = 0; v < NV; v++) begin
            logic [19:0] e;
            e = VEC[v];
            send(e[19], e[18], e[17:10], e[9:7], e[6]);
            if (e[5:0] < 6'd32) m_lvl[e[4:0]] = e[6];
            chk(TAG[v], irq_out, model_out());
        end

        // R5: disable group 7, line 31 drops, a new request on line 29 stays low
        wr_map(7, 32'h7FFF_FFFF);
        chk("R5", irq_out, model_out());
        send(1'b1, 1'b1, 8'h18, 3'd1, 1'b1);
        m_lvl[29] = 1'b1;
        chk("R5", {31'd0, irq_out[29]}, 32'd0);

        // R10: re-enable restores lines 29 and 31; disabling group 0 drops lines 2 and 3
        wr_map(7, 32'h8000_0000);
        chk("R10", irq_out, model_out());
        chk("R10", {30'd0, irq_out[31], irq_out[29]}, 32'd3);
        wr_map(0, 32'h0000_0000);
        chk("R10", irq_out, model_out());

        // R4: reset after enables were set
        do_reset();
        chk("R4", irq_out, '0);
        for (int i = 0; i < NUM_MAPS; i++) rd_chk("R4", i, 1'b0);

        // R1: stored levels were cleared by reset
        wr_map(1, 32'h8000_0000);
        chk("R1", irq_out, '0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule